// File: doc/BRIEF.md
# Masked Bus Debug Comparator

This block watches the bus of a CPU and reports a one-cycle pulse when a bus cycle matches a programmed compare address and compare data. A mask selects which data bits take part in the compare. The compare can also require a given access direction and a given access size. The block has two output modes. In forced mode the pulse follows the matching bus cycle directly. In tagged mode, only the address of an opcode fetch is compared, and the pulse waits until that instruction executes. If the fetch is flushed before it executes, there is no pulse.

The block is set up through a byte-wide register port. The compare registers sit behind a 2-bit bank select, and only bank 00 reaches them. The control register can be reached from every bank. The arm bit makes the unit live. While the unit is armed, every setting except the arm bit is frozen.

Top module: `bus_watch_cmp`

## Requirements
- R1: After reset every register reads 0 and `match_o` is low.
- R2: The data compare uses a 16-bit mask. Mask byte offset 5 covers data bits 15:8 and offset 6 covers bits 7:0. A mask bit of 1 requires the bus data bit to equal the compare data bit. A mask bit of 0 lets that bus bit take any value.
- R3: With the tag bit (control bit 2) set, the data is not compared. A valid fetch (`fetch_i`) whose address equals the compare address marks the instruction as tagged. `match_o` is high in the cycle after `exec_i` is asserted for a tagged instruction. A fetch whose address differs gives no pulse.
- R4: `flush_i` drops a pending tag, so no pulse follows. When `flush_i` and `exec_i` arrive in the same cycle, the flush wins. When `exec_i` and a new matching fetch arrive in the same cycle, the pulse fires and a new tag is left pending.
- R5: Control bit 3 set requires `bus_rd_i` to equal control bit 4, where 1 means read. This applies in forced mode.
- R6: Control bit 5 set requires `bus_word_i` to equal control bit 6, where 1 means word. This applies in forced mode.
- R7: In forced mode, a valid bus cycle that matches makes `match_o` high for exactly the next cycle.
- R8: Register offsets 1 to 6 (address high, address low, data high, data low, mask high, mask low) can be reached only when `reg_sel_i` is 00. In any other bank they read 0 and ignore writes. Offset 0, the control register, can be reached from every bank. Offset 7 reads 0.
- R9: While the arm bit (control bit 0) is set, writes to offsets 1 to 6 are ignored. A write to the control register then changes only the arm bit. Reads always return the current contents.
- R10: `match_o` stays low unless both the arm bit and the enable bit (control bit 1) are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 2 | Register bank select |
| reg_addr_i | input | 3 | Register offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| bus_valid_i | input | 1 | A bus cycle is present |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_data_i | input | 16 | Bus data |
| bus_rd_i | input | 1 | 1 = read, 0 = write |
| bus_word_i | input | 1 | 1 = word, 0 = byte |
| fetch_i | input | 1 | The bus cycle is an opcode fetch |
| exec_i | input | 1 | The most recently fetched instruction executes |
| flush_i | input | 1 | The fetched instruction is discarded |
| match_o | output | 1 | Match pulse |

## Verification
In tagged mode, the execution of a pending tag can coincide with an event that changes that same tag. The bench drives `exec_i` and `flush_i` together for a tagged instruction and expects no pulse, then confirms that a later `exec_i` also stays quiet. It then drives `exec_i` in the same cycle as a new matching fetch. It expects a pulse in that cycle and a second pulse from the next lone `exec_i`, which shows that the new tag survived the firing of the old one.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef struct packed {
    logic sz_val;
    logic sz_chk;
    logic rw_val;
    logic rw_chk;
    logic tag;
    logic en;
    logic arm;
  } ctl_t;

  localparam logic [2:0] OFS_CTL   = 3'd0;
  localparam logic [2:0] OFS_ADR_H = 3'd1;
  localparam logic [2:0] OFS_ADR_L = 3'd2;
  localparam logic [2:0] OFS_DAT_H = 3'd3;
  localparam logic [2:0] OFS_DAT_L = 3'd4;
  localparam logic [2:0] OFS_MSK_H = 3'd5;
  localparam logic [2:0] OFS_MSK_L = 3'd6;
endpackage

// File: rtl/bwc_regs.sv
module bwc_regs
  import bwc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [2:0]        addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output ctl_t              ctl_o,
  output logic [ADDR_W-1:0] cmp_addr_o,
  output logic [15:0]       cmp_data_o,
  output logic [15:0]       mask_o
);
  localparam int AREG_W = 16;

  ctl_t              ctl_q;
  logic [AREG_W-1:0] addr_q;
  logic [15:0]       data_q, mask_q;
  logic              bank_ok, cmp_wr;

  assign bank_ok = (sel_i == '0);
  assign cmp_wr  = we_i && bank_ok && !ctl_q.arm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      if (we_i && addr_i == OFS_CTL) begin
        // armed: only the arm bit may change
        if (ctl_q.arm) ctl_q.arm <= wdata_i[0];
        else           ctl_q     <= wdata_i[6:0];
      end
      if (cmp_wr) begin
        unique case (addr_i)
          OFS_ADR_H: addr_q[15:8] <= wdata_i;
          OFS_ADR_L: addr_q[7:0]  <= wdata_i;
          OFS_DAT_H: data_q[15:8] <= wdata_i;
          OFS_DAT_L: data_q[7:0]  <= wdata_i;
          OFS_MSK_H: mask_q[15:8] <= wdata_i;
          OFS_MSK_L: mask_q[7:0]  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_CTL) rdata_o = {1'b0, ctl_q};
    else if (bank_ok) begin
      unique case (addr_i)
        OFS_ADR_H: rdata_o = addr_q[15:8];
        OFS_ADR_L: rdata_o = addr_q[7:0];
        OFS_DAT_H: rdata_o = data_q[15:8];
        OFS_DAT_L: rdata_o = data_q[7:0];
        OFS_MSK_H: rdata_o = mask_q[15:8];
        OFS_MSK_L: rdata_o = mask_q[7:0];
        default:   rdata_o = '0;
      endcase
    end
  end

  assign ctl_o      = ctl_q;
  assign cmp_addr_o = addr_q[ADDR_W-1:0];
  assign cmp_data_o = data_q;
  assign mask_o     = mask_q;

  // R9: compare settings frozen while armed
  a_r9_cmp_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.arm |=> $stable(addr_q) && $stable(data_q) && $stable(mask_q));
  a_r9_ctl_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.arm |=> $stable(ctl_q[6:1]));
endmodule

// File: rtl/bwc_cmp.sv
module bwc_cmp
  import bwc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  ctl_t              ctl_i,
  input  logic [ADDR_W-1:0] cmp_addr_i,
  input  logic [15:0]       cmp_data_i,
  input  logic [15:0]       mask_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [15:0]       bus_data_i,
  input  logic              bus_rd_i,
  input  logic              bus_word_i,
  output logic              addr_hit_o,
  output logic              full_hit_o
);
  logic data_ok, rw_ok, sz_ok;

  assign addr_hit_o = (bus_addr_i == cmp_addr_i);
  assign data_ok    = ((bus_data_i ^ cmp_data_i) & mask_i) == '0;
  assign rw_ok      = !ctl_i.rw_chk || (bus_rd_i == ctl_i.rw_val);
  assign sz_ok      = !ctl_i.sz_chk || (bus_word_i == ctl_i.sz_val);
  assign full_hit_o = addr_hit_o && data_ok && rw_ok && sz_ok;
endmodule

// File: rtl/bwc_fire.sv
module bwc_fire
  import bwc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ctl_t ctl_i,
  input  logic bus_valid_i,
  input  logic fetch_i,
  input  logic exec_i,
  input  logic flush_i,
  input  logic addr_hit_i,
  input  logic full_hit_i,
  output logic match_o
);
  logic live, tag_mode, pend_q, hit, tag_fetch;

  assign live      = ctl_i.arm && ctl_i.en;
  assign tag_mode  = live && ctl_i.tag;
  assign tag_fetch = bus_valid_i && fetch_i && addr_hit_i;

  always_comb begin
    hit = 1'b0;
    if (tag_mode)  hit = exec_i && pend_q && !flush_i;
    else if (live) hit = bus_valid_i && full_hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      match_o <= 1'b0;
    end else begin
      match_o <= hit;
      if (!tag_mode)      pend_q <= 1'b0;
      else if (flush_i)   pend_q <= 1'b0;
      else if (tag_fetch) pend_q <= 1'b1;
      else if (exec_i)    pend_q <= 1'b0;
    end
  end

  a_r10_needs_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_i.arm && ctl_i.en) |=> !match_o);
  a_r4_flush_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.tag && flush_i) |=> !match_o);
  a_r3_needs_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.tag && !exec_i) |=> !match_o);
  a_r7_needs_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.tag && !bus_valid_i) |=> !match_o);
endmodule

// File: rtl/bus_watch_cmp.sv
module bus_watch_cmp
  import bwc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [2:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              bus_valid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [15:0]       bus_data_i,
  input  logic              bus_rd_i,
  input  logic              bus_word_i,
  input  logic              fetch_i,
  input  logic              exec_i,
  input  logic              flush_i,
  output logic              match_o
);
  ctl_t              ctl;
  logic [ADDR_W-1:0] cmp_addr;
  logic [15:0]       cmp_data, mask;
  logic              addr_hit, full_hit;

  bwc_regs #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni,
    .sel_i(reg_sel_i), .addr_i(reg_addr_i), .we_i(reg_we_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .ctl_o(ctl), .cmp_addr_o(cmp_addr), .cmp_data_o(cmp_data), .mask_o(mask)
  );

  bwc_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .ctl_i(ctl), .cmp_addr_i(cmp_addr), .cmp_data_i(cmp_data), .mask_i(mask),
    .bus_addr_i, .bus_data_i, .bus_rd_i, .bus_word_i,
    .addr_hit_o(addr_hit), .full_hit_o(full_hit)
  );

  bwc_fire u_fire (
    .clk_i, .rst_ni, .ctl_i(ctl),
    .bus_valid_i, .fetch_i, .exec_i, .flush_i,
    .addr_hit_i(addr_hit), .full_hit_i(full_hit), .match_o
  );
endmodule

// File: tb/bus_watch_cmp_bench.sv
module bus_watch_cmp_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        bus_valid = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic        bus_rd = 1'b0, bus_word = 1'b0;
  logic        fetch = 1'b0, exec_s = 1'b0, flush = 1'b0;
  logic        match;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_watch_cmp u_bus_watch_cmp (
    .clk_i(clk), .rst_ni,
    .reg_sel_i(reg_sel), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .bus_valid_i(bus_valid), .bus_addr_i(bus_addr), .bus_data_i(bus_data),
    .bus_rd_i(bus_rd), .bus_word_i(bus_word),
    .fetch_i(fetch), .exec_i(exec_s), .flush_i(flush), .match_o(match)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [2:0] a, input logic [7:0] d);
    reg_sel = sel; reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; reg_sel = '0;
  endtask

  task automatic rd(input string req, input logic [1:0] sel, input logic [2:0] a,
                    input logic [7:0] exp);
    reg_sel = sel; reg_addr = a; #1;
    chk(req, reg_rdata, exp);
    reg_sel = '0;
  endtask

  // one cycle of bus/pipeline activity, then check the pulse it produced
  task automatic cyc(input string req, input logic v, input logic [15:0] a,
                     input logic [15:0] d, input logic r, input logic w,
                     input logic f, input logic x, input logic fl, input logic exp);
    bus_valid = v; bus_addr = a; bus_data = d; bus_rd = r; bus_word = w;
    fetch = f; exec_s = x; flush = fl;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; fetch = 0; exec_s = 0; flush = 0;
    chk(req, {15'd0, match}, {15'd0, exp});
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) rd("R1 reg", 2'b00, 3'(i), 8'h00);
    chk("R1 match", {15'd0, match}, 16'd0);
  endtask

  task automatic t_mask;
    wr(0, 1, 8'h12); wr(0, 2, 8'h34);
    wr(0, 3, 8'hA5); wr(0, 4, 8'hC3);
    wr(0, 5, 8'hFF); wr(0, 6, 8'h00);
    wr(0, 0, 8'h03);
    cyc("R2 low byte ignored", 1, 16'h1234, 16'hA577, 1, 1, 0, 0, 0, 1);
    cyc("R7 single pulse", 0, 16'h1234, 16'hA577, 1, 1, 0, 0, 0, 0);
    cyc("R2 high byte compared", 1, 16'h1234, 16'hB5C3, 1, 1, 0, 0, 0, 0);
    cyc("R7 addr miss", 1, 16'h1235, 16'hA5C3, 1, 1, 0, 0, 0, 0);
    wr(0, 0, 8'h02);
    wr(0, 5, 8'h00); wr(0, 6, 8'h0F);
    wr(0, 0, 8'h03);
    cyc("R2 low nibble match", 1, 16'h1234, 16'hFFF3, 0, 0, 0, 0, 0, 1);
    cyc("R2 low nibble miss", 1, 16'h1234, 16'hA5C2, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_qual;
    wr(0, 0, 8'h02); wr(0, 0, 8'h1B);
    cyc("R5 write rejected", 1, 16'h1234, 16'h00C3, 0, 0, 0, 0, 0, 0);
    cyc("R5 read accepted", 1, 16'h1234, 16'h00C3, 1, 0, 0, 0, 0, 1);
    wr(0, 0, 8'h02); wr(0, 0, 8'h23);
    cyc("R6 word rejected", 1, 16'h1234, 16'h00C3, 1, 1, 0, 0, 0, 0);
    cyc("R6 byte accepted", 1, 16'h1234, 16'h00C3, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_tag;
    wr(0, 0, 8'h02); wr(0, 0, 8'h07);
    cyc("R3 fetch no pulse", 1, 16'h1234, 16'h0000, 1, 0, 1, 0, 0, 0);
    cyc("R3 exec pulse", 0, 16'h0, 16'h0, 0, 0, 0, 1, 0, 1);
    cyc("R3 fetch", 1, 16'h1234, 16'h0000, 1, 0, 1, 0, 0, 0);
    cyc("R4 flush", 0, 16'h0, 16'h0, 0, 0, 0, 0, 1, 0);
    cyc("R4 exec after flush", 0, 16'h0, 16'h0, 0, 0, 0, 1, 0, 0);
    cyc("R3 fetch", 1, 16'h1234, 16'h0000, 1, 0, 1, 0, 0, 0);
    cyc("R4 exec with flush", 0, 16'h0, 16'h0, 0, 0, 0, 1, 1, 0);
    cyc("R4 exec after both", 0, 16'h0, 16'h0, 0, 0, 0, 1, 0, 0);
    cyc("R3 fetch", 1, 16'h1234, 16'h0000, 1, 0, 1, 0, 0, 0);
    cyc("R4 exec with new fetch", 1, 16'h1234, 16'h0000, 1, 0, 1, 1, 0, 1);
    cyc("R4 retagged exec", 0, 16'h0, 16'h0, 0, 0, 0, 1, 0, 1);
    cyc("R3 fetch other addr", 1, 16'h1236, 16'h00C3, 1, 0, 1, 0, 0, 0);
    cyc("R3 exec untagged", 0, 16'h0, 16'h0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_gate;
    wr(0, 0, 8'h00);
    rd("R9 disarm keeps rest", 0, 0, 8'h06);
    wr(0, 0, 8'h01);
    cyc("R10 armed not enabled", 1, 16'h1234, 16'h00C3, 0, 0, 0, 0, 0, 0);
    wr(0, 0, 8'h00); wr(0, 0, 8'h02);
    cyc("R10 enabled not armed", 1, 16'h1234, 16'h00C3, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_bank;
    wr(1, 5, 8'h77);
    rd("R8 other bank write ignored", 0, 5, 8'h00);
    rd("R8 other bank reads 0", 1, 6, 8'h00);
    rd("R8 ctl in any bank", 2, 0, 8'h02);
    rd("R8 offset 7", 0, 7, 8'h00);
  endtask

  task automatic t_lock;
    wr(0, 0, 8'h03);
    wr(0, 6, 8'hAA);
    rd("R9 mask locked", 0, 6, 8'h0F);
    wr(0, 0, 8'h7D);
    rd("R9 ctl locked", 0, 0, 8'h03);
    wr(0, 0, 8'h00);
    rd("R9 arm still writable", 0, 0, 8'h02);
    wr(0, 6, 8'hAA);
    rd("R9 unlocked write", 0, 6, 8'hAA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_qual();
    t_tag();
    t_gate();
    t_bank();
    t_lock();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule